// File: doc/BRIEF.md
# Multichannel RC Servo Pulse Generator

This block drives a bank of RC servo outputs that all share one frame. One free-running frame counter sets the frame length. Every enabled output rises when a frame starts and falls once the counter reaches that channel's own on-time. The timing unit is one clock cycle. With a 20 ns clock, a 20 ms frame therefore takes a period value of 1,000,000.

Software reaches the block through a plain synchronous register port. A write is taken on the rising clock edge while `reg_we` is high. Reads have no strobe: `reg_rdata` combinationally shows the register selected by `reg_addr`. No data stream crosses the block's edge, so every pin is a plain control or status signal with no valid/ready handshake.

The register map has three parts. Address 0 holds the frame period. Address 1 holds the configuration word, with a global run bit and one enable bit per channel. Addresses 2 upward hold the per-channel on-times, one for each channel in channel order. Period and on-time writes go into staging registers. Their values are copied to the active copies at a frame boundary, so a pulse is never cut or stretched in the middle of a frame.

Top module: `servo_pwm_bank`

## Requirements
- R1: After reset, every register reads zero and every `servo_o` bit is low.
- R2: The register map is:
  - address 0: period;
  - address 1: configuration;
  - address 2+i: on-time of channel i.
  
  Each of these reads back the value last written to it. Any other address reads zero, and a write to it changes no register.
- R3: While running, the frame counter steps 0, 1, …, period−1 and then starts over at 0. With a period of 0 or 1 it stays at 0.
- R4: Output i is high exactly while the counter is below the active on-time of channel i, provided channel i and the global run bit are both enabled.
- R5: An on-time of 0 keeps the output low. An on-time at or above the active nonzero period keeps the output high for the whole frame.
- R6: The global run bit is configuration bit 31. While it is clear, every output is low and the counter is held at 0. The frame after it is set begins at count 0 in the first cycle after the write.
- R7: Configuration bit i enables channel i. When it is clear, that output is low and the other outputs are unaffected. Enable bits act in the cycle after the write.
- R8: A period or on-time write while running becomes active only at the next frame boundary, which is the edge after the counter shows period−1. While the run bit is clear, the active copies follow the written values every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is the timing unit |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address for writes and reads |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| servo_o | output | 8 | Servo pulse outputs, bit i is channel i |

## Verification
The assertions take the following for granted about the inputs:
- `reg_we`, `reg_addr` and `reg_wdata` are known and settled around each rising edge;
- at most one register is written per cycle;
- reset is held for at least one edge before the first access.

The bench meets these conditions by changing inputs only on falling edges and by issuing writes one at a time. Before loading a new pattern, it clears the run bit, so each pattern starts from a known frame phase. The one exception is the deferred-update case, where writes land mid-frame on purpose.

// File: rtl/servo_pkg.sv
package servo_pkg;
  // Fixed register positions; on-times follow consecutively by channel.
  localparam int ADDR_PERIOD  = 0;
  localparam int ADDR_CONFIG  = 1;
  localparam int ADDR_ON_BASE = 2;
endpackage

// File: rtl/servo_regs.sv
module servo_regs
  import servo_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [DATA_W-1:0]             wdata,
  input  logic                          load,
  output logic [DATA_W-1:0]             rdata,
  output logic [DATA_W-1:0]             cfg,
  output logic [DATA_W-1:0]             period_act,
  output logic [NUM_CH-1:0][DATA_W-1:0] on_act
);
  logic [DATA_W-1:0]             period_q;
  logic [NUM_CH-1:0][DATA_W-1:0] on_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      period_q   <= '0;
      cfg        <= '0;
      period_act <= '0;
    end else begin
      if (we && addr == ADDR_W'(ADDR_PERIOD)) period_q <= wdata;
      if (we && addr == ADDR_W'(ADDR_CONFIG)) cfg      <= wdata;
      if (load) period_act <= period_q;
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_on
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        on_q[i]   <= '0;
        on_act[i] <= '0;
      end else begin
        if (we && addr == ADDR_W'(ADDR_ON_BASE + i)) on_q[i] <= wdata;
        if (load) on_act[i] <= on_q[i];
      end
    end

    // Active on-time only moves at a load point
    p_on_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(on_act[i]));
  end

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(ADDR_PERIOD)) rdata = period_q;
    if (addr == ADDR_W'(ADDR_CONFIG)) rdata = cfg;
    for (int i = 0; i < NUM_CH; i++)
      if (addr == ADDR_W'(ADDR_ON_BASE + i)) rdata = on_q[i];
  end

  p_period_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(period_act));
endmodule

// File: rtl/servo_frame_ctr.sv
module servo_frame_ctr #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] cnt,
  output logic             frame_end
);
  logic [CNT_W:0] cnt_next;

  assign cnt_next  = {1'b0, cnt} + 1'b1;
  assign frame_end = run && (cnt_next >= {1'b0, period});

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt <= '0;
    else if (!run || frame_end) cnt <= '0;
    else                       cnt <= cnt_next[CNT_W-1:0];
  end

  p_hold_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt == '0);

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run && !frame_end |=> cnt == $past(cnt) + 1'b1);

  p_below_period_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run && period != '0 |-> cnt < period);
endmodule

// File: rtl/servo_chan.sv
module servo_chan #(
  parameter int CNT_W = 32
) (
  input  logic             enable,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] on_time,
  output logic             pulse
);
  always_comb pulse = enable && (cnt < on_time);
endmodule

// File: rtl/servo_pwm_bank.sv
module servo_pwm_bank #(
  parameter int NUM_CH  = 8,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8,
  parameter int RUN_BIT = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [NUM_CH-1:0] servo_o
);
  logic [DATA_W-1:0]             cfg;
  logic [DATA_W-1:0]             period_act;
  logic [NUM_CH-1:0][DATA_W-1:0] on_act;
  logic [DATA_W-1:0]             cnt;
  logic                          frame_end;
  logic                          run;
  logic                          load;

  assign run  = cfg[RUN_BIT];
  assign load = !run || frame_end;

  servo_regs #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .load(load), .rdata(reg_rdata), .cfg(cfg), .period_act(period_act),
    .on_act(on_act)
  );

  servo_frame_ctr #(.CNT_W(DATA_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .run(run), .period(period_act),
    .cnt(cnt), .frame_end(frame_end)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    servo_chan #(.CNT_W(DATA_W)) u_chan (
      .enable(run && cfg[i]), .cnt(cnt), .on_time(on_act[i]), .pulse(servo_o[i])
    );

    p_full_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
      run && cfg[i] && period_act != '0 && on_act[i] >= period_act |-> servo_o[i]);
  end

  p_all_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> servo_o == '0);
endmodule

// File: tb/servo_pwm_bank_tb.sv
module servo_pwm_bank_tb;
  localparam int NCH = 8;
  localparam logic [31:0] RUN = 32'h8000_0000;
  // {period[15:0], on_even[15:0], on_odd[15:0], mask[7:0]}
  localparam logic [55:0] VEC [0:5] = '{
    {16'd10, 16'd3, 16'd7,  8'hFF},
    {16'd8,  16'd0, 16'd8,  8'hFF},
    {16'd6,  16'd9, 16'd1,  8'h55},
    {16'd1,  16'd1, 16'd0,  8'hFF},
    {16'd0,  16'd2, 16'd0,  8'h0F},
    {16'd12, 16'd5, 16'd11, 8'hAA}
  };

  logic clk = 0, rst_n = 0, reg_we = 0;
  logic [7:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic [NCH-1:0] servo_o;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  servo_pwm_bank u_dut (.clk(clk), .rst_n(rst_n), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .servo_o(servo_o));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  function automatic logic [NCH-1:0] model(input int p, input int on_e, input int on_o,
                                           input logic [7:0] m, input int k);
    int ph;
    ph = (p == 0) ? 0 : k % p;
    for (int i = 0; i < NCH; i++)
      model[i] = m[i] && (ph < ((i % 2 == 0) ? on_e : on_o));
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int miss;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: reset state
    chk("R1 outputs", {24'd0, servo_o}, 32'd0);
    miss = 0;
    for (int a = 0; a < 2 + NCH; a++) begin
      rd(8'(a), d);
      if (d != 0) miss++;
    end
    chk("R1 regs zero", miss, 0);

    // R2: readback and unmapped address
    wr(8'd0, 32'h0001_2345);
    wr(8'd1, 32'h0000_00A5);
    for (int i = 0; i < NCH; i++) wr(8'(2 + i), 32'h100 + i);
    wr(8'd10, 32'hDEAD_BEEF);
    rd(8'd0, d); chk("R2 period readback", d, 32'h0001_2345);
    rd(8'd1, d); chk("R2 config readback", d, 32'h0000_00A5);
    miss = 0;
    for (int i = 0; i < NCH; i++) begin
      rd(8'(2 + i), d);
      if (d != 32'h100 + i) miss++;
    end
    chk("R2 on-time readback", miss, 0);
    rd(8'd10, d); chk("R2 unmapped reads zero", d, 0);
    chk("R2 R6 no output without run bit", {24'd0, servo_o}, 32'd0);
    @(negedge clk);

    // R3 R4 R5 R7: vector table walk
    for (int v = 0; v < 6; v++) begin
      int p, oe, oo, n;
      logic [7:0] m;
      p = int'(VEC[v][55:40]); oe = int'(VEC[v][39:24]);
      oo = int'(VEC[v][23:8]); m = VEC[v][7:0];
      wr(8'd1, 32'd0);
      wr(8'd0, 32'(p));
      for (int i = 0; i < NCH; i++) wr(8'(2 + i), 32'((i % 2 == 0) ? oe : oo));
      wr(8'd1, RUN | {24'd0, m});
      n = 3 * ((p == 0) ? 1 : p) + 2;
      miss = 0;
      for (int k = 0; k < n; k++) begin
        if (servo_o !== model(p, oe, oo, m, k)) miss++;
        @(negedge clk);
      end
      chk($sformatf("R3 R4 R5 R7 vector %0d mismatches", v), miss, 0);
    end

    // R6: clearing run bit forces low and restarts the frame at zero
    wr(8'd1, 32'd0);
    wr(8'd0, 32'd10);
    for (int i = 0; i < NCH; i++) wr(8'(2 + i), (i % 2 == 0) ? 32'd3 : 32'd7);
    wr(8'd1, RUN | 32'hFF);
    repeat (5) @(negedge clk);
    wr(8'd1, 32'h0000_00FF);
    miss = 0;
    for (int k = 0; k < 5; k++) begin
      if (servo_o !== '0) miss++;
      @(negedge clk);
    end
    chk("R6 outputs low while run clear", miss, 0);
    wr(8'd1, RUN | 32'hFF);
    miss = 0;
    for (int k = 0; k < 12; k++) begin
      if (servo_o !== model(10, 3, 7, 8'hFF, k)) miss++;
      @(negedge clk);
    end
    chk("R6 frame restarts at zero", miss, 0);

    // R8: mid-frame period and on-time writes wait for the boundary
    wr(8'd1, 32'd0);
    wr(8'd2, 32'd3);
    wr(8'd1, RUN | 32'h01);
    wr(8'd0, 32'd5);
    wr(8'd2, 32'd2);
    miss = 0;
    for (int k = 2; k < 30; k++) begin
      logic expv;
      expv = (k < 10) ? (k < 3) : (((k - 10) % 5) < 2);
      if (servo_o !== {7'd0, expv}) miss++;
      @(negedge clk);
    end
    chk("R8 deferred update", miss, 0);

    // R7: single-channel enable leaves others low
    wr(8'd1, RUN | 32'h04);
    chk("R7 only channel 2", {24'd0, servo_o}, 32'h0000_0004);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule